// File: doc/BRIEF.md
# Character Display Command Controller

This block drives a parallel character-display module over an 8-bit write-only bus. The bus has a register-select line, a read/write line and an enable strobe. A client hands over one request at a time through a valid/ready handshake. Each request names either a display instruction or a character byte. Instructions are given as a kind code plus up to three option flags, and the controller assembles the instruction byte from them.

For every accepted request the controller walks a fixed sequence. It places the byte and register select on the bus and holds them through a setup interval. It then raises enable for a fixed number of cycles, drops it, and stays busy for the time the display needs to carry out the transfer. Clearing the screen and returning the cursor home are slow operations and get the long wait; all other transfers get the short wait. The bus keeps its last value while the controller is idle.

The state machine has four states:
- IDLE: ready is high. A valid request moves it to SETUP (transition *accept*).
- SETUP: the bus is driven and enable is low. When the setup count expires it moves to PULSE (transition *strobe*).
- PULSE: enable is high. When the pulse count expires it moves to WAIT (transition *release*).
- WAIT: enable is low again. When the execution delay expires it returns to IDLE (transition *complete*).

Top module: `lcd_cmd_if`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `lcd_db` is 0x00, `lcd_rs` and `lcd_en` are 0, and `req_ready` is 1.
- R2: `lcd_rw` is always 0. `lcd_rs` is 0 for instruction kinds 0 to 5 and 1 for kinds 6 and 7.
- R3: Kind 0 (clear) sends 0x01. Kind 1 (home) sends 0x02. The flags and data inputs are ignored for both.
- R4: Kind 2 (entry mode) sends 0b000001 followed by `req_flags[1]` (cursor direction, 1 = increment) and `req_flags[0]` (display shift enable) in bits 1 and 0.
- R5: Kind 3 (display control) sends 0b00001 followed by `req_flags[2]` (display on), `req_flags[1]` (cursor on) and `req_flags[0]` (blink on) in bits 2 to 0.
- R6: Kind 4 (shift) sends 0b0001 in bits 7 to 4, `req_flags[1]` (1 = shift display, 0 = move cursor) in bit 3, `req_flags[0]` (1 = right) in bit 2, and 0 in bits 1 and 0.
- R7: Kind 5 (function set) sends 0b001 in bits 7 to 5, `req_flags[2]` (8-bit bus), `req_flags[1]` (two lines) and `req_flags[0]` (5x10 font) in bits 4 to 2, and 0 in bits 1 and 0.
- R8: Kinds 6 and 7 send `req_data` unchanged, with `lcd_rs` = 1.
- R9: Take the clock edge that accepts a request as edge 0. From edge 0 the bus and `lcd_rs` carry the new value and `lcd_en` stays low for SETUP_CYC cycles. `lcd_en` is then high for exactly PULSE_CYC cycles, rising after edge SETUP_CYC.
- R10: After `lcd_en` falls, the controller stays busy for LONG_WAIT cycles for kinds 0 and 1 and SHORT_WAIT cycles for all other kinds. `req_ready` is high again after edge SETUP_CYC+PULSE_CYC+wait.
- R11: A request is accepted only on an edge where `req_valid` and `req_ready` are both high. A request offered while `req_ready` is low has no effect, and `lcd_db` and `lcd_rs` stay stable until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | Controller is idle and can accept a request |
| req_kind | input | 3 | Request kind: 0 clear, 1 home, 2 entry mode, 3 display control, 4 shift, 5 function set, 6 and 7 character data |
| req_flags | input | 3 | Option flags for the instruction kinds |
| req_data | input | 8 | Character byte for kinds 6 and 7 |
| lcd_db | output | 8 | Display data bus |
| lcd_rs | output | 1 | Register select (0 instruction, 1 data) |
| lcd_rw | output | 1 | Read/write line, held at write (0) |
| lcd_en | output | 1 | Enable strobe |

## Verification
Every result is due at a fixed offset from the accepting edge.
- The bus value and register select change at edge 0.
- Enable rises after edge SETUP_CYC and falls after edge SETUP_CYC+PULSE_CYC.
- Ready returns after the wait for that kind has also elapsed.

The bench keeps a behavioural model that counts cycles remaining and cycles elapsed per transfer. It compares every output 2 ns after each rising edge. Any misplaced strobe, wrong wait length or early acceptance therefore shows up in the exact cycle it happens. Requests offered while busy are aimed into the busy window, and the every-cycle comparison confirms that they leave the bus untouched.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    typedef enum logic [2:0] {
        K_CLEAR   = 3'd0,
        K_HOME    = 3'd1,
        K_ENTRY   = 3'd2,
        K_DISPLAY = 3'd3,
        K_SHIFT   = 3'd4,
        K_FUNC    = 3'd5,
        K_DATA    = 3'd6,
        K_DATA_B  = 3'd7
    } lcdc_kind_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SETUP = 2'd1,
        S_PULSE = 2'd2,
        S_WAIT  = 2'd3
    } lcdc_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lcdc_encode.sv
module lcdc_encode
    import lcdc_pkg::*;
(
    input  logic [2:0] kind,
    input  logic [2:0] flags,
    input  logic [7:0] data,
    output logic [7:0] code,
    output logic       rs,
    output logic       slow
);

    lcdc_kind_e k;
    assign k = lcdc_kind_e'(kind);

    always_comb begin
        code = 8'h00;
        rs   = 1'b0;
        slow = 1'b0;
        unique case (k)
            K_CLEAR: begin
                code = 8'h01;
                slow = 1'b1;
            end
            K_HOME: begin
                code = 8'h02;
                slow = 1'b1;
            end
            K_ENTRY:   code = {6'b000001, flags[1], flags[0]};
            K_DISPLAY: code = {5'b00001, flags[2], flags[1], flags[0]};
            K_SHIFT:   code = {4'b0001, flags[1], flags[0], 2'b00};
            K_FUNC:    code = {3'b001, flags[2], flags[1], flags[0], 2'b00};
            K_DATA, K_DATA_B: begin
                code = data;
                rs   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/lcdc_timer.sv
module lcdc_timer #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/lcd_cmd_if.sv
module lcd_cmd_if
    import lcdc_pkg::*;
#(
    parameter int unsigned SETUP_CYC  = 2,
    parameter int unsigned PULSE_CYC  = 4,
    parameter int unsigned SHORT_WAIT = 6,
    parameter int unsigned LONG_WAIT  = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic [2:0] req_kind,
    input  logic [2:0] req_flags,
    input  logic [7:0] req_data,
    output logic [7:0] lcd_db,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_en
);

    localparam int unsigned MAX_CYC = max2(max2(SETUP_CYC, PULSE_CYC), max2(SHORT_WAIT, LONG_WAIT));
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_SHORT = CNT_W'(SHORT_WAIT - 1);
    localparam logic [CNT_W-1:0] LD_LONG  = CNT_W'(LONG_WAIT - 1);

    lcdc_state_e      st_q, st_n;
    logic             fire;
    logic [7:0]       enc_code;
    logic             enc_rs, enc_slow;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic [7:0]       db_q;
    logic             rs_q, en_q, slow_q;

    lcdc_encode u_enc (
        .kind  (req_kind),
        .flags (req_flags),
        .data  (req_data),
        .code  (enc_code),
        .rs    (enc_rs),
        .slow  (enc_slow)
    );

    lcdc_timer #(.W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    assign req_ready = (st_q == S_IDLE);
    assign fire      = req_valid && req_ready;

    // next state and timer loading
    always_comb begin
        st_n     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st_q)
            S_IDLE: if (fire) begin
                st_n     = S_SETUP;
                tmr_load = 1'b1;
                tmr_val  = LD_SETUP;
            end
            S_SETUP: if (tmr_done) begin
                st_n     = S_PULSE;
                tmr_load = 1'b1;
                tmr_val  = LD_PULSE;
            end
            S_PULSE: if (tmr_done) begin
                st_n     = S_WAIT;
                tmr_load = 1'b1;
                tmr_val  = slow_q ? LD_LONG : LD_SHORT;
            end
            S_WAIT: if (tmr_done) begin
                st_n = S_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_n;
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            db_q   <= 8'h00;
            rs_q   <= 1'b0;
            slow_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            if (fire) begin
                db_q   <= enc_code;
                rs_q   <= enc_rs;
                slow_q <= enc_slow;
            end
            en_q <= (st_n == S_PULSE);
        end
    end

    assign lcd_db = db_q;
    assign lcd_rs = rs_q;
    assign lcd_rw = 1'b0;
    assign lcd_en = en_q;

    // R9: enable only rises straight out of the setup interval
    p_setup_before_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |-> $past(st_q == S_SETUP));

    // R9/R10: enable falls when the wait begins
    p_en_fall_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_q) |-> (st_q == S_WAIT));

    // R10: an expired wait returns the controller to idle
    p_wait_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_WAIT && tmr_done) |=> req_ready);

    // R11: acceptance takes the controller busy
    p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R11: bus stays stable while busy
    p_bus_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> ($stable(db_q) && $stable(rs_q)));

endmodule

// File: tb/sim_lcd_cmd_if.sv
`timescale 1ns/1ps
module sim_lcd_cmd_if;

    localparam int S  = 2;
    localparam int P  = 4;
    localparam int WS = 6;
    localparam int WL = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [2:0] req_kind = 3'd0;
    logic [2:0] req_flags = 3'd0;
    logic [7:0] req_data = 8'h00;
    logic [7:0] lcd_db;
    logic       lcd_rs, lcd_rw, lcd_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    lcd_cmd_if #(.SETUP_CYC(S), .PULSE_CYC(P), .SHORT_WAIT(WS), .LONG_WAIT(WL)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_flags(req_flags), .req_data(req_data),
        .lcd_db(lcd_db), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en));

    // ---- reference model ----
    int         rem = 0;
    int         el = 0;
    logic [7:0] m_db = 8'h00;
    logic       m_rs = 1'b0;
    string      tag = "R1";

    function automatic logic [7:0] want_code(input logic [2:0] k, input logic [2:0] f, input logic [7:0] d);
        int v;
        case (k)
            3'd0: v = 1;                                          // R3 clear
            3'd1: v = 2;                                          // R3 home
            3'd2: v = 4 + 2 * f[1] + f[0];                        // R4
            3'd3: v = 8 + 4 * f[2] + 2 * f[1] + f[0];             // R5
            3'd4: v = 16 + 8 * f[1] + 4 * f[0];                   // R6
            3'd5: v = 32 + 16 * f[2] + 8 * f[1] + 4 * f[0];       // R7
            default: v = int'(d);                                 // R8
        endcase
        return v[7:0];
    endfunction

    function automatic string kind_tag(input logic [2:0] k);
        case (k)
            3'd0, 3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R8";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            rem = 0; el = 0; m_db = 8'h00; m_rs = 1'b0; tag = "R1";
        end else if (rem == 0) begin
            if (req_valid) begin
                m_db = want_code(req_kind, req_flags, req_data);
                m_rs = (req_kind >= 3'd6);
                rem  = S + P + ((req_kind <= 3'd1) ? WL : WS);
                el   = 0;
                tag  = kind_tag(req_kind);
            end
        end else begin
            if (req_valid) tag = "R11";
            rem = rem - 1;
            el  = el + 1;
        end
    end

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #2;
        chk(tag, int'(lcd_db), int'(m_db));
        chk("R2", int'(lcd_rs), int'(m_rs));
        chk("R2", int'(lcd_rw), 0);
        chk("R9", int'(lcd_en), int'(rem > 0 && el >= S && el < S + P));
        chk((rst_n ? "R10" : "R1"), int'(req_ready), int'(rem == 0));
    end

    // ---- stimulus ----
    task automatic send(input logic [2:0] k, input logic [2:0] f, input logic [7:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_flags = f; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // R11: offer a request while busy; it must be ignored
    task automatic poke_busy(input logic [2:0] k, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_flags = 3'b111; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        send(3'd0, 3'b111, 8'hFF);           // R3 clear, long wait R10
        send(3'd1, 3'b000, 8'h00);           // R3 home
        for (int i = 0; i < 4; i++) send(3'd2, 3'(i), 8'h00);  // R4
        send(3'd3, 3'b100, 8'h00);           // R5
        send(3'd3, 3'b011, 8'h00);
        send(3'd3, 3'b111, 8'h00);
        for (int i = 0; i < 4; i++) send(3'd4, 3'(i), 8'h00);  // R6
        send(3'd5, 3'b110, 8'h00);           // R7
        send(3'd5, 3'b001, 8'h00);
        send(3'd6, 3'b000, 8'hA5);           // R8
        poke_busy(3'd0, 8'h00);              // R11
        send(3'd7, 3'b101, 8'h3C);           // R8 alternate kind
        poke_busy(3'd6, 8'h77);              // R11
        poke_busy(3'd6, 8'h88);
        send(3'd0, 3'b000, 8'h00);
        send(3'd6, 3'b000, 8'h5A);
        repeat (40) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule